// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects 32 interrupt request lines and turns them into two processor interrupt outputs: a fast one for latency-critical events and a normal one for everything else. Each source has an enable bit and a routing bit that picks the output it drives. A software register can raise any source without hardware involvement.

For the normal output, the block also supplies the start address of the handler to run. Sixteen programmable slots each bind one source number to one handler address. Priority is fixed. Slot 0 ranks highest and slot 15 lowest. A single shared default address covers any normal request that no slot claims.

A second controller can be cascaded through a chain request and a chain vector input. Its vector is used when no local slot matches. A small register port gives software access to the following:
- request status;
- the current vector;
- end-of-service acknowledgement.

Reading the vector marks its priority level as in service. Writing the vector register retires that level.

Top module: `vpic_top`

## Requirements
- R1: `fiq_o` is high one cycle after any source that is enabled (ENABLE, address 0x03) and routed fast (bit set in ROUTE, address 0x04) is active. Such a source never raises `irq_o`.
- R2: A source that is enabled and has its ROUTE bit clear raises `irq_o` one cycle later, provided its level is not hidden (R8).
- R3: A source whose ENABLE bit is clear affects neither output. It still reads as 1 in the RAW status register (address 0x00). The fast status register (0x01) and the normal status register (0x02) show only enabled sources.
- R4: The SOFT register (address 0x05) is ORed bit for bit with the source lines before masking, and reads back as written.
- R5: Slot n has two registers. Its address register is at 0x10+n. Its control register is at 0x20+n, with bits [4:0] holding the source number and bit 5 the slot enable. `vec_o` carries the address of the lowest-numbered enabled slot whose source is an active normal request.
- R6: A slot whose enable bit is clear takes no part in selection. Its source then counts as a non-vectored request.
- R7: When no slot matches, `vec_o` selects from two values. It is `chain_vec_i` if `chain_req_i` is high. Otherwise it is the DEFAULT register (address 0x07). `chain_req_i` alone raises `irq_o`. Whenever `irq_o` is low, `vec_o` shows DEFAULT.
- R8: Reading VECTOR (address 0x06) does two things:
  - It returns the current vector, one cycle later on `bus_rdata_o`.
  - It marks the winning level as in service. From then on, only strictly higher-priority levels raise `irq_o` and appear on `vec_o`.
  A read made while nothing is eligible changes nothing.
- R9: Any write to VECTOR retires the highest-priority in-service level. This restores the level that was active before it.
- R10: After reset, the outputs are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt request lines, active high |
| chain_req_i | input | 1 | Request from a cascaded controller |
| chain_vec_i | input | DW | Vector from a cascaded controller |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid the cycle after the read strobe |
| fiq_o | output | 1 | Fast interrupt output (registered) |
| irq_o | output | 1 | Normal interrupt output (registered) |
| vec_o | output | DW | Handler address for the normal interrupt (registered) |

## Verification
Every result has a fixed latency:
- A change on `src_i` or `chain_req_i` reaches `fiq_o`, `irq_o` and `vec_o` one clock later.
- A register write takes effect on the edge that accepts it, so outputs follow on the edge after that.
- Read data appears on the edge that accepts the read.
- A vector read or acknowledge moves the in-service level at its own edge, so `irq_o` reflects the new level one edge later.

The bench drives inputs on falling edges. It waits exactly those edges and samples on the next falling edge, so every check sees the settled value of the cycle it targets.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned BUS_AW = 6;
  localparam logic [BUS_AW-1:0] A_RAW   = 6'h00;
  localparam logic [BUS_AW-1:0] A_FAST  = 6'h01;
  localparam logic [BUS_AW-1:0] A_NORM  = 6'h02;
  localparam logic [BUS_AW-1:0] A_ENA   = 6'h03;
  localparam logic [BUS_AW-1:0] A_ROUTE = 6'h04;
  localparam logic [BUS_AW-1:0] A_SOFT  = 6'h05;
  localparam logic [BUS_AW-1:0] A_VEC   = 6'h06;
  localparam logic [BUS_AW-1:0] A_DFLT  = 6'h07;
  localparam logic [1:0] PG_SADDR = 2'b01;
  localparam logic [1:0] PG_SCTL  = 2'b10;
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned SW   = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   route_q,
  output logic [NSRC-1:0]   soft_q,
  output logic [DW-1:0]     dflt_q,
  output logic [SW-1:0]     slot_src [NSLOT],
  output logic [NSLOT-1:0]  slot_en,
  output logic [DW-1:0]     slot_addr [NSLOT]
);
  logic wr_en;
  assign wr_en = bus_sel && bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '0;
      soft_q  <= '0;
      dflt_q  <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_ENA:   en_q    <= bus_wdata[NSRC-1:0];
        A_ROUTE: route_q <= bus_wdata[NSRC-1:0];
        A_SOFT:  soft_q  <= bus_wdata[NSRC-1:0];
        A_DFLT:  dflt_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_addr[s] <= '0;
        slot_src[s]  <= '0;
        slot_en[s]   <= 1'b0;
      end else if (wr_en && bus_addr[3:0] == 4'(s)) begin
        if (bus_addr[5:4] == PG_SADDR) slot_addr[s] <= bus_wdata;
        if (bus_addr[5:4] == PG_SCTL) begin
          slot_src[s] <= bus_wdata[SW-1:0];
          slot_en[s]  <= bus_wdata[SW];
        end
      end
    end
  end

  // R4
  soft_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == A_SOFT) |=> (soft_q == $past(bus_wdata[NSRC-1:0])));
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned SW   = $clog2(NSRC),
  localparam int unsigned LW   = $clog2(NSLOT + 2)
) (
  input  logic [NSRC-1:0]  norm_act,
  input  logic [SW-1:0]    slot_src [NSLOT],
  input  logic [NSLOT-1:0] slot_en,
  input  logic [DW-1:0]    slot_addr [NSLOT],
  input  logic             chain_req,
  input  logic [DW-1:0]    chain_vec,
  input  logic [DW-1:0]    dflt_vec,
  input  logic [LW-1:0]    ceil_lvl,
  output logic [LW-1:0]    win_lvl,
  output logic [DW-1:0]    win_vec,
  output logic             win_ok
);
  logic [NSLOT-1:0] hit;

  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    assign hit[s] = slot_en[s] && norm_act[slot_src[s]];
  end

  always_comb begin
    win_lvl = LW'(NSLOT + 1);
    win_vec = dflt_vec;
    if (hit == '0) begin
      if ((|norm_act) || chain_req) begin
        win_lvl = LW'(NSLOT);
        win_vec = chain_req ? chain_vec : dflt_vec;
      end
    end else begin
      for (int s = NSLOT - 1; s >= 0; s--) begin
        if (hit[s]) begin
          win_lvl = LW'(s);
          win_vec = slot_addr[s];
        end
      end
    end
  end

  assign win_ok = win_lvl < ceil_lvl;
endmodule

// File: rtl/vpic_svc.sv
module vpic_svc #(
  parameter int unsigned NSLOT = 16,
  localparam int unsigned LW   = $clog2(NSLOT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          ack,
  input  logic [LW-1:0] win_lvl,
  input  logic          win_ok,
  output logic [LW-1:0] ceil_lvl
);
  logic [NSLOT:0] inserv;

  always_ff @(posedge clk) begin
    if (rst) inserv <= '0;
    else if (take && win_ok) inserv[win_lvl] <= 1'b1;
    else if (ack) inserv <= inserv & (inserv - 1'b1);
  end

  always_comb begin
    ceil_lvl = LW'(NSLOT + 1);
    for (int i = NSLOT; i >= 0; i--) begin
      if (inserv[i]) ceil_lvl = LW'(i);
    end
  end

  // R8
  take_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    (take && win_ok) |=> (ceil_lvl == $past(win_lvl)));

  // R9
  ack_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !take && inserv != '0) |=> ($countones(inserv) + 1 == $past($countones(inserv))));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned SW   = $clog2(NSRC),
  localparam int unsigned LW   = $clog2(NSLOT + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              chain_req_i,
  input  logic [DW-1:0]     chain_vec_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o,
  output logic [DW-1:0]     vec_o
);
  logic [NSRC-1:0]  en_q, route_q, soft_q;
  logic [DW-1:0]    dflt_q;
  logic [SW-1:0]    slot_src [NSLOT];
  logic [NSLOT-1:0] slot_en;
  logic [DW-1:0]    slot_addr [NSLOT];
  logic [NSRC-1:0]  raw, fin, fast_act, norm_act;
  logic [LW-1:0]    win_lvl, ceil_lvl;
  logic [DW-1:0]    win_vec, cur_vec, rd_mux;
  logic             win_ok, rd_vec, ack;

  vpic_regs #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel_i), .bus_wr(bus_wr_i),
    .bus_addr(bus_addr_i), .bus_wdata(bus_wdata_i),
    .en_q(en_q), .route_q(route_q), .soft_q(soft_q), .dflt_q(dflt_q),
    .slot_src(slot_src), .slot_en(slot_en), .slot_addr(slot_addr)
  );

  assign raw      = src_i | soft_q;
  assign fin      = raw & en_q;
  assign fast_act = fin & route_q;
  assign norm_act = fin & ~route_q;

  vpic_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_prio (
    .norm_act(norm_act), .slot_src(slot_src), .slot_en(slot_en),
    .slot_addr(slot_addr), .chain_req(chain_req_i), .chain_vec(chain_vec_i),
    .dflt_vec(dflt_q), .ceil_lvl(ceil_lvl),
    .win_lvl(win_lvl), .win_vec(win_vec), .win_ok(win_ok)
  );

  assign rd_vec = bus_sel_i && !bus_wr_i && bus_addr_i == A_VEC;
  assign ack    = bus_sel_i && bus_wr_i && bus_addr_i == A_VEC;

  vpic_svc #(.NSLOT(NSLOT)) u_svc (
    .clk(clk), .rst(rst), .take(rd_vec), .ack(ack),
    .win_lvl(win_lvl), .win_ok(win_ok), .ceil_lvl(ceil_lvl)
  );

  assign cur_vec = win_ok ? win_vec : dflt_q;

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i[5:4])
      PG_SADDR: if (32'(bus_addr_i[3:0]) < NSLOT) rd_mux = slot_addr[bus_addr_i[3:0]];
      PG_SCTL:  if (32'(bus_addr_i[3:0]) < NSLOT)
                  rd_mux = DW'({slot_en[bus_addr_i[3:0]], slot_src[bus_addr_i[3:0]]});
      2'b00: begin
        case (bus_addr_i)
          A_RAW:   rd_mux = DW'(raw);
          A_FAST:  rd_mux = DW'(fast_act);
          A_NORM:  rd_mux = DW'(norm_act);
          A_ENA:   rd_mux = DW'(en_q);
          A_ROUTE: rd_mux = DW'(route_q);
          A_SOFT:  rd_mux = DW'(soft_q);
          A_VEC:   rd_mux = cur_vec;
          A_DFLT:  rd_mux = dflt_q;
          default: rd_mux = '0;
        endcase
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o       <= 1'b0;
      irq_o       <= 1'b0;
      vec_o       <= '0;
      bus_rdata_o <= '0;
    end else begin
      fiq_o <= |fast_act;
      irq_o <= win_ok;
      vec_o <= cur_vec;
      if (bus_sel_i && !bus_wr_i) bus_rdata_o <= rd_mux;
    end
  end

  // R1
  fiq_src_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> $past(|(route_q & en_q)));

  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past((|((src_i | soft_q) & en_q & ~route_q)) || chain_req_i));

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && !win_ok) |=> $stable(ceil_lvl));
endmodule

// File: tb/vpic_top_bench.sv
module vpic_top_bench;
  import vpic_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        chain_req = 1'b0;
  logic [31:0] chain_vec = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, vec;
  logic        fiq, irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vpic_top u_vpic_top (
    .clk(clk), .rst(rst), .src_i(src), .chain_req_i(chain_req),
    .chain_vec_i(chain_vec), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .fiq_o(fiq), .irq_o(irq), .vec_o(vec)
  );

  // {src, fiq, irq, vec}; slot s binds source 16+s at 0x1000+16*s, slot 3 off,
  // source 0 fast, source 31 disabled, default 0xDEF0
  localparam logic [65:0] TBL [10] = '{
    {32'h0000_0000, 1'b0, 1'b0, 32'h0000_DEF0},
    {32'h0000_0001, 1'b1, 1'b0, 32'h0000_DEF0},
    {32'h0001_0000, 1'b0, 1'b1, 32'h0000_1000},
    {32'h0012_0000, 1'b0, 1'b1, 32'h0000_1010},
    {32'h0008_0000, 1'b0, 1'b1, 32'h0000_DEF0},
    {32'h0208_0000, 1'b0, 1'b1, 32'h0000_1090},
    {32'h0000_0020, 1'b0, 1'b1, 32'h0000_DEF0},
    {32'h8000_0000, 1'b0, 1'b0, 32'h0000_DEF0},
    {32'hC000_0001, 1'b1, 1'b1, 32'h0000_10E0},
    {32'h0001_0020, 1'b0, 1'b1, 32'h0000_1000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    step();
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    step();
    sel = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    step();
    // R10 reset state
    check("R10 fiq", {31'd0, fiq}, 0);
    check("R10 irq", {31'd0, irq}, 0);
    check("R10 vec", vec, 0);
    bus_read(A_ENA, rd);  check("R10 enable", rd, 0);
    bus_read(A_DFLT, rd); check("R10 default", rd, 0);

    bus_write(A_ENA, 32'h7FFF_FFFF);
    bus_write(A_ROUTE, 32'h0000_0001);
    bus_write(A_DFLT, 32'h0000_DEF0);
    for (int s = 0; s < 16; s++) begin
      bus_write(6'h10 + 6'(s), 32'h1000 + 32'(s) * 16);
      bus_write(6'h20 + 6'(s), ((s != 3) ? 32'h20 : 32'h0) | (32'd16 + 32'(s)));
    end
    bus_read(6'h25, rd); check("R5 slot ctl readback", rd, 32'h35);

    // R1 R2 R3 R5 R6 R7 table walk
    for (int i = 0; i < 10; i++) begin
      src = TBL[i][65:34];
      step();
      check($sformatf("R1 fiq row %0d", i), {31'd0, fiq}, {31'd0, TBL[i][33]});
      check($sformatf("R2 irq row %0d", i), {31'd0, irq}, {31'd0, TBL[i][32]});
      check($sformatf("R5 vec row %0d", i), vec, TBL[i][31:0]);
    end

    // R3 status registers with a masked source
    src = 32'h8000_0001;
    step();
    bus_read(A_RAW, rd);  check("R3 raw", rd, 32'h8000_0001);
    bus_read(A_NORM, rd); check("R3 normal status", rd, 0);
    bus_read(A_FAST, rd); check("R3 fast status", rd, 1);
    check("R3 irq masked", {31'd0, irq}, 0);

    // R4 software interrupt
    src = 0;
    bus_write(A_SOFT, 32'h0004_0000);
    step();
    check("R4 irq", {31'd0, irq}, 1);
    check("R4 vec", vec, 32'h1020);
    bus_read(A_SOFT, rd); check("R4 readback", rd, 32'h0004_0000);
    bus_read(A_RAW, rd);  check("R4 raw", rd, 32'h0004_0000);
    bus_write(A_SOFT, 0);

    // R7 chain
    chain_vec = 32'hC0DE; chain_req = 1'b1;
    step();
    check("R7 chain alone irq", {31'd0, irq}, 1);
    check("R7 chain alone vec", vec, 32'hC0DE);
    src = 32'h0000_0020;
    step();
    check("R7 chain vec", vec, 32'hC0DE);
    src = 32'h0002_0020;
    step();
    check("R7 slot beats chain", vec, 32'h1010);
    chain_req = 1'b0; src = 0;
    step();

    // R8 R9 nesting
    bus_read(A_VEC, rd); check("R8 idle read", rd, 32'hDEF0);
    src = 32'h0010_0000;
    step();
    check("R8 vec before", vec, 32'h1040);
    bus_read(A_VEC, rd); check("R8 read slot4", rd, 32'h1040);
    step();
    check("R8 irq hidden", {31'd0, irq}, 0);
    check("R8 vec hidden", vec, 32'hDEF0);
    src = 32'h0012_0000;
    step();
    check("R8 higher irq", {31'd0, irq}, 1);
    check("R8 higher vec", vec, 32'h1010);
    bus_read(A_VEC, rd); check("R8 read slot1", rd, 32'h1010);
    step();
    check("R8 nested hidden", {31'd0, irq}, 0);
    bus_write(A_VEC, 0);
    step();
    check("R9 ack restores", {31'd0, irq}, 1);
    check("R9 ack vec", vec, 32'h1010);
    src = 32'h0010_0000;
    step();
    check("R9 slot4 still hidden", {31'd0, irq}, 0);
    bus_write(A_VEC, 0);
    step();
    check("R9 final ack", {31'd0, irq}, 1);
    check("R9 final vec", vec, 32'h1040);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule